// File: doc/BRIEF.md
# DMA address sequence generator

This block produces, for one side of a DMA channel, the address of the current beat, the size of the operand moved on that beat and the byte lanes it touches on a 32-bit data path. A 3-bit sequence code picks one rule that covers both how the address moves and how wide each operand is. Some codes step the address by a fixed amount or by the size of the current transfer. Other codes keep the address fixed, as a peripheral data register needs.

A channel uses two instances, one for the read side and one for the write side. The channel loads a start address with a load strobe. It then pulses a beat-advance strobe once per completed beat. In auto-size mode a separate size input sets both the operand size and the step. The two reserved codes produce no beats and raise a configuration-error flag. Bus handshaking and byte counting are left to the surrounding channel logic.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset the stored address is zero, so with code 000 the outputs show address 0, size byte (size encoding 00 = byte, 01 = halfword, 10 = word) and byte enable 0001 (bit n of the byte enable = byte lane n, where lane n holds address LSBs equal to n).
- R2: A load strobe stores the start address at the next clock edge, and load takes priority over a simultaneous advance.
- R3: Code 000 adds 1 to the address on each accepted beat, reports size 00, and enables the single lane given by address bits [1:0].
- R4: Code 001 reports size 01, shows the address with bit 0 forced to zero, adds 2 on each beat, and enables lanes 0011 when address bit 1 is 0 and 1100 when it is 1.
- R5: Code 010 takes its size from the auto-size input (value 11 is treated as word), adds 1, 2 or 4 on each beat to match, and enables the lanes of that aligned operand.
- R6: Code 011 keeps the address on a beat, reports size 00, and enables exactly one lane chosen by address bits [1:0].
- R7: Code 100 keeps the address on a beat, reports size 01, forces address bit 0 to zero, and enables 0011 or 1100 according to address bit 1.
- R8: Code 101 keeps the address on a beat, reports size 10, forces address bits [1:0] to zero, and enables all four lanes (1111).
- R9: Codes 110 and 111 raise the configuration-error output, enable no lanes (0000), accept no beats, and leave the stored address unchanged when advance is pulsed.
- R10: With neither load nor an accepted beat, the stored address holds its value.
- R11: The beat-accept output equals the advance strobe in the same cycle whenever the code is valid.
- R12: Address arithmetic wraps modulo 2 to the power of the address width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| seq_code_i | input | 3 | Sequence code selecting step rule and operand size |
| auto_size_i | input | 2 | Operand size used by code 010 |
| load_i | input | 1 | Stores start_addr_i at the next edge |
| start_addr_i | input | ADDR_W | Start address for the sequence |
| advance_i | input | 1 | One pulse per completed beat |
| addr_o | output | ADDR_W | Address of the current beat, aligned as the code requires |
| size_o | output | 2 | Operand size of the current beat |
| byte_en_o | output | 4 | Byte lanes touched by the current beat |
| beat_o | output | 1 | Advance accepted this cycle |
| cfg_err_o | output | 1 | Reserved sequence code selected |

## Verification
The stored address is the only register. A load or an accepted beat therefore shows on addr_o and byte_en_o one clock edge later. Size, byte enables, beat accept and the error flag follow the code and auto-size inputs with no delay. The bench drives inputs on the falling edge and checks registered results at the next falling edge, after exactly one rising edge. Combinational results are checked in the same half cycle, a short delay after the inputs change. To check that an advance under a reserved code has no effect, the bench switches back to a valid code and reads the address.

// File: rtl/dma_addr_seq_pkg.sv
package dma_addr_seq_pkg;

   typedef enum logic [2:0] {
      SEQ_INC_BYTE = 3'b000,
      SEQ_INC_HALF = 3'b001,
      SEQ_INC_AUTO = 3'b010,
      SEQ_FIX_BYTE = 3'b011,
      SEQ_FIX_HALF = 3'b100,
      SEQ_FIX_WORD = 3'b101,
      SEQ_RSV_6    = 3'b110,
      SEQ_RSV_7    = 3'b111
   } seq_code_e;

   typedef enum logic [1:0] {
      XFER_BYTE = 2'b00,
      XFER_HALF = 2'b01,
      XFER_WORD = 2'b10,
      XFER_RSVD = 2'b11
   } xfer_size_e;

   typedef struct packed {
      xfer_size_e size;
      logic       moving;
      logic       align;
      logic       err;
   } seq_ctrl_t;

endpackage

// File: rtl/dma_seq_decode.sv
module dma_seq_decode
   import dma_addr_seq_pkg::*;
(
   input  logic [2:0] code_i,
   input  logic [1:0] auto_size_i,
   output seq_ctrl_t  ctrl_o
);

   xfer_size_e auto_sz;

   always_comb begin
      if (auto_size_i == 2'b11) auto_sz = XFER_WORD;
      else                      auto_sz = xfer_size_e'(auto_size_i);
   end

   always_comb begin
      ctrl_o = '{size: XFER_BYTE, moving: 1'b0, align: 1'b0, err: 1'b0};
      unique case (seq_code_e'(code_i))
         SEQ_INC_BYTE: ctrl_o = '{size: XFER_BYTE, moving: 1'b1, align: 1'b0, err: 1'b0};
         SEQ_INC_HALF: ctrl_o = '{size: XFER_HALF, moving: 1'b1, align: 1'b1, err: 1'b0};
         SEQ_INC_AUTO: ctrl_o = '{size: auto_sz,   moving: 1'b1, align: 1'b0, err: 1'b0};
         SEQ_FIX_BYTE: ctrl_o = '{size: XFER_BYTE, moving: 1'b0, align: 1'b0, err: 1'b0};
         SEQ_FIX_HALF: ctrl_o = '{size: XFER_HALF, moving: 1'b0, align: 1'b1, err: 1'b0};
         SEQ_FIX_WORD: ctrl_o = '{size: XFER_WORD, moving: 1'b0, align: 1'b1, err: 1'b0};
         default:      ctrl_o = '{size: XFER_BYTE, moving: 1'b0, align: 1'b0, err: 1'b1};
      endcase
   end

endmodule

// File: rtl/dma_seq_lane_en.sv
module dma_seq_lane_en #(
   parameter int LANES  = 4,
   localparam int LANE_W = $clog2(LANES)
) (
   input  logic [LANE_W-1:0] lsb_i,
   input  logic [1:0]        size_i,
   input  logic              valid_i,
   output logic [LANES-1:0]  be_o
);

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      localparam logic [LANE_W-1:0] IDX = LANE_W'(ln);
      assign be_o[ln] = valid_i && ((IDX >> size_i) == (lsb_i >> size_i));
   end

endmodule

// File: rtl/dma_seq_addr_reg.sv
module dma_seq_addr_reg #(
   parameter int ADDR_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] start_i,
   input  logic              step_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [1:0]        size_i,
   output logic [ADDR_W-1:0] addr_q_o
);

   logic [ADDR_W-1:0] incr;
   logic [ADDR_W-1:0] addr_d;

   assign incr = ADDR_W'(1) << size_i;

   always_comb begin
      addr_d = addr_q_o;
      if (load_i)      addr_d = start_i;
      else if (step_i) addr_d = base_i + incr;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) addr_q_o <= '0;
      else         addr_q_o <= addr_d;
   end

endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
   import dma_addr_seq_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   localparam int LANES  = DATA_W / 8,
   localparam int LANE_W = $clog2(LANES)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [2:0]        seq_code_i,
   input  logic [1:0]        auto_size_i,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic              advance_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [1:0]        size_o,
   output logic [3:0]        byte_en_o,
   output logic              beat_o,
   output logic              cfg_err_o
);

   if (DATA_W != 32) begin : g_bad_data_w
      $error("dma_addr_seq: DATA_W must be 32");
   end
   if (ADDR_W < 8) begin : g_bad_addr_w
      $error("dma_addr_seq: ADDR_W must be at least 8");
   end

   seq_ctrl_t         ctrl;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] low_mask;
   logic [ADDR_W-1:0] addr_view;
   logic [LANES-1:0]  lane_en;

   dma_seq_decode u_decode (
      .code_i      (seq_code_i),
      .auto_size_i (auto_size_i),
      .ctrl_o      (ctrl)
   );

   // Aligned view: clear the low address bits below the operand size.
   assign low_mask  = (ADDR_W'(1) << ctrl.size) - ADDR_W'(1);
   assign addr_view = ctrl.align ? (addr_q & ~low_mask) : addr_q;

   assign beat_o    = advance_i && !ctrl.err;
   assign cfg_err_o = ctrl.err;
   assign size_o    = ctrl.size;
   assign addr_o    = addr_view;

   dma_seq_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load_i),
      .start_i  (start_addr_i),
      .step_i   (beat_o && ctrl.moving),
      .base_i   (addr_view),
      .size_i   (ctrl.size),
      .addr_q_o (addr_q)
   );

   dma_seq_lane_en #(.LANES(LANES)) u_lanes (
      .lsb_i   (addr_view[LANE_W-1:0]),
      .size_i  (ctrl.size),
      .valid_i (!ctrl.err),
      .be_o    (lane_en)
   );

   assign byte_en_o = lane_en;

endmodule

// File: rtl/dma_addr_seq_chk.sv
module dma_addr_seq_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [2:0]        seq_code_i,
   input logic              load_i,
   input logic [ADDR_W-1:0] start_addr_i,
   input logic              advance_i,
   input logic [ADDR_W-1:0] addr_o,
   input logic [1:0]        size_o,
   input logic [3:0]        byte_en_o,
   input logic              beat_o,
   input logic              cfg_err_o,
   input logic [ADDR_W-1:0] addr_q
);

   logic fixed_code;
   assign fixed_code = (seq_code_i == 3'b011) || (seq_code_i == 3'b100) ||
                       (seq_code_i == 3'b101);

   a_r2_load_stores: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> addr_q == $past(start_addr_i));

   a_r6_single_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seq_code_i == 3'b011) |-> ($countones(byte_en_o) == 1 && size_o == 2'b00));

   a_r7_half_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seq_code_i == 3'b100) |-> (addr_o[0] == 1'b0 && $countones(byte_en_o) == 2));

   a_r8_word_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seq_code_i == 3'b101) |-> (byte_en_o == 4'hF && addr_o[1:0] == 2'b00));

   a_r9_no_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_err_o |-> (!beat_o && byte_en_o == 4'h0));

   a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && !beat_o) |=> $stable(addr_q));

   a_r6_fixed_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && fixed_code) |=> $stable(addr_q));

   a_r11_beat_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg_err_o) |-> (beat_o == advance_i));

endmodule

bind dma_addr_seq dma_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .seq_code_i   (seq_code_i),
   .load_i       (load_i),
   .start_addr_i (start_addr_i),
   .advance_i    (advance_i),
   .addr_o       (addr_o),
   .size_o       (size_o),
   .byte_en_o    (byte_en_o),
   .beat_o       (beat_o),
   .cfg_err_o    (cfg_err_o),
   .addr_q       (addr_q)
);

// File: tb/dma_addr_seq_tb.sv
module dma_addr_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  code = 3'b000;
   logic [1:0]  asize = 2'b00;
   logic        load = 1'b0;
   logic [31:0] start = '0;
   logic        adv = 1'b0;
   logic [31:0] addr;
   logic [1:0]  size;
   logic [3:0]  be;
   logic        beat;
   logic        err;

   int n_run = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   dma_addr_seq u_dut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .seq_code_i   (code),
      .auto_size_i  (asize),
      .load_i       (load),
      .start_addr_i (start),
      .advance_i    (adv),
      .addr_o       (addr),
      .size_o       (size),
      .byte_en_o    (be),
      .beat_o       (beat),
      .cfg_err_o    (err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      #1;
   endtask

   task automatic do_load(input logic [2:0] c, input logic [31:0] a);
      code = c; start = a; load = 1'b1; adv = 1'b0;
      tick();
      load = 1'b0;
      #1;
   endtask

   task automatic do_adv();
      adv = 1'b1;
      tick();
      adv = 1'b0;
      #1;
   endtask

   task automatic t_reset();
      code = 3'b000; #1;
      chk("R1 addr", addr, 32'h0);
      chk("R1 size", {30'b0, size}, 32'h0);
      chk("R1 be", {28'b0, be}, 32'h1);
      chk("R1 err", {31'b0, err}, 32'h0);
   endtask

   task automatic t_load();
      do_load(3'b000, 32'h0000_1003);
      chk("R2 addr", addr, 32'h1003);
      chk("R3 be", {28'b0, be}, 32'h8);
      start = 32'h0000_1100; load = 1'b1; adv = 1'b1;
      tick();
      load = 1'b0; adv = 1'b0; #1;
      chk("R2 priority", addr, 32'h1100);
   endtask

   task automatic t_inc_byte();
      do_load(3'b000, 32'h0000_2002);
      adv = 1'b1; #1;
      chk("R11 beat", {31'b0, beat}, 32'h1);
      tick(); adv = 1'b0; #1;
      chk("R3 step1", addr, 32'h2003);
      chk("R3 be1", {28'b0, be}, 32'h8);
      do_adv();
      chk("R3 step2", addr, 32'h2004);
      chk("R3 be2", {28'b0, be}, 32'h1);
      chk("R3 size", {30'b0, size}, 32'h0);
   endtask

   task automatic t_inc_half();
      do_load(3'b001, 32'h0000_3001);
      chk("R4 align", addr, 32'h3000);
      chk("R4 be lo", {28'b0, be}, 32'h3);
      chk("R4 size", {30'b0, size}, 32'h1);
      do_adv();
      chk("R4 step1", addr, 32'h3002);
      chk("R4 be hi", {28'b0, be}, 32'hC);
      do_adv();
      chk("R4 step2", addr, 32'h3004);
   endtask

   task automatic t_auto();
      do_load(3'b010, 32'h0000_4000);
      asize = 2'b00; do_adv();
      chk("R5 byte step", addr, 32'h4001);
      do_adv();
      chk("R5 byte step2", addr, 32'h4002);
      asize = 2'b01; #1;
      chk("R5 half be", {28'b0, be}, 32'hC);
      do_adv();
      chk("R5 half step", addr, 32'h4004);
      asize = 2'b10; #1;
      chk("R5 word be", {28'b0, be}, 32'hF);
      do_adv();
      chk("R5 word step", addr, 32'h4008);
      asize = 2'b11; #1;
      chk("R5 size 11 as word", {30'b0, size}, 32'h2);
      do_adv();
      chk("R5 size 11 step", addr, 32'h400C);
      asize = 2'b00;
   endtask

   task automatic t_fixed_byte();
      do_load(3'b011, 32'h0000_5002);
      chk("R6 be", {28'b0, be}, 32'h4);
      for (int i = 0; i < 3; i++) do_adv();
      chk("R6 hold", addr, 32'h5002);
      chk("R6 size", {30'b0, size}, 32'h0);
   endtask

   task automatic t_fixed_half();
      do_load(3'b100, 32'h0000_6003);
      chk("R7 align", addr, 32'h6002);
      chk("R7 be", {28'b0, be}, 32'hC);
      chk("R7 size", {30'b0, size}, 32'h1);
      do_adv();
      chk("R7 hold", addr, 32'h6002);
   endtask

   task automatic t_fixed_word();
      do_load(3'b101, 32'h0000_7007);
      chk("R8 align", addr, 32'h7004);
      chk("R8 be", {28'b0, be}, 32'hF);
      chk("R8 size", {30'b0, size}, 32'h2);
      do_adv();
      chk("R8 hold", addr, 32'h7004);
   endtask

   task automatic t_reserved();
      do_load(3'b000, 32'h0000_8000);
      code = 3'b110; adv = 1'b1; #1;
      chk("R9 err 110", {31'b0, err}, 32'h1);
      chk("R9 no beat", {31'b0, beat}, 32'h0);
      chk("R9 be", {28'b0, be}, 32'h0);
      tick();
      code = 3'b111; #1;
      chk("R9 err 111", {31'b0, err}, 32'h1);
      tick();
      adv = 1'b0; code = 3'b000; #1;
      chk("R9 addr kept", addr, 32'h8000);
   endtask

   task automatic t_idle();
      do_load(3'b000, 32'h0000_9005);
      for (int i = 0; i < 5; i++) tick();
      chk("R10 idle hold", addr, 32'h9005);
   endtask

   task automatic t_wrap();
      do_load(3'b000, 32'hFFFF_FFFF);
      do_adv();
      chk("R12 wrap", addr, 32'h0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      t_reset();
      t_load();
      t_inc_byte();
      t_inc_half();
      t_auto();
      t_fixed_byte();
      t_fixed_half();
      t_fixed_word();
      t_reserved();
      t_idle();
      t_wrap();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule